// File: doc/BRIEF.md
# SCSI Controller Register Front End

This block is the register-level face of a SCSI bus controller, seen by a processor through two memory-mapped windows. The byte window holds a bank of sixteen 8-bit registers. They are spaced four bytes apart, so the two low address bits are ignored. One of these registers is a command port. Writes to it start operations and are never stored. The word window holds four 32-bit DMA registers that work as plain read/write storage.

The block models a controller with no target on the bus. A select-with-attention command therefore finishes at once as a failed selection. It loads fixed status, interrupt-cause and sequence-step values and raises an interrupt line. The interrupt stays raised until software pulses a clear strobe or issues a chip reset. Chip reset returns every register to its power-up value. The other recognised commands are accepted and change nothing. Reads are combinational and have no side effects. A value written at one clock edge can be read back in the next cycle.

Top module: `scsi_regfront`

## Requirements
- R1: After reset, every byte register reads 0x00 except index 14, which reads 0x04 as an identification code. All four DMA registers read 0, and `irq` is low.
- R2: The byte register index is `reg_addr[5:2]`, and `reg_addr[1:0]` has no effect. The DMA register index is `dma_addr[3:2]`, and `dma_addr[1:0]` has no effect.
- R3: A write to index 0, 1, 2 or 8 stores the byte, which can be read back in the next cycle.
- R4: Writes to indices 4 to 7 and 9 to 15 are ignored, and these registers keep their values.
- R5: A write to index 3 is a command. Only `reg_wdata[6:0]` is decoded, the byte is never stored, and index 3 always reads 0x00.
- R6: Command 0x42 (select with attention) sets index 4 to 0x1A, index 5 to 0x20 and index 6 to 0x04, and raises `irq` from the next cycle. Bit 7 of the command byte is ignored, so 0xC2 acts the same way.
- R7: Command 0x02 (chip reset) restores the full R1 state in one cycle, including the DMA registers and `irq`. It takes priority over a DMA write in the same cycle.
- R8: Commands 0x00 (no operation), 0x03 (bus reset) and 0x1A (set attention) change no state, and neither does any unrecognised command code.
- R9: Once raised, `irq` stays high until a cycle with `irq_clr` high or a chip reset command. If a select command and `irq_clr` arrive in the same cycle, the select wins and `irq` stays high.
- R10: Each DMA register stores a full 32-bit write and returns it on read. The other three DMA registers are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Byte-window write strobe |
| reg_addr | input | 6 | Byte-window address |
| reg_wdata | input | 8 | Byte-window write data |
| reg_rdata | output | 8 | Byte-window read data at `reg_addr` |
| dma_wr_en | input | 1 | DMA-window write strobe |
| dma_addr | input | 4 | DMA-window address |
| dma_wdata | input | 32 | DMA-window write data |
| dma_rdata | output | 32 | DMA-window read data at `dma_addr` |
| irq_clr | input | 1 | Interrupt clear strobe |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a select command and a clear strobe landing in the same cycle, because software seldom produces that collision on its own. The bench first drives both inputs on the same edge and then releases the clear, which shows that the select wins. A chip reset is issued only after the DMA registers and the bank hold non-zero data, so the restored values can be told apart from values that were never written. The select command is sent with bit 7 set, which proves that bit is not decoded.

// File: rtl/scsi_regfront.sv
module scsi_regfront #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int DMA_W  = 32,
  parameter int DMA_N  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr_en,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic                        dma_wr_en,
  input  logic [$clog2(DMA_N)+1:0]    dma_addr,
  input  logic [DMA_W-1:0]            dma_wdata,
  output logic [DMA_W-1:0]            dma_rdata,
  input  logic                        irq_clr,
  output logic                        irq
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int NREG   = 1 << IDX_W;
  localparam int DSEL_W = $clog2(DMA_N);
  localparam int CMD_IDX  = 3;
  localparam int STAT_IDX = 4;
  localparam int INTR_IDX = 5;
  localparam int SEQ_IDX  = 6;
  localparam int ID_IDX   = 14;
  localparam logic [DATA_W-1:0] ID_VAL   = DATA_W'(8'h04);
  localparam logic [DATA_W-1:0] STAT_VAL = DATA_W'(8'h1A);
  localparam logic [DATA_W-1:0] INTR_VAL = DATA_W'(8'h20);
  localparam logic [DATA_W-1:0] SEQ_VAL  = DATA_W'(8'h04);

  logic [DATA_W-1:0] bank [NREG];
  logic [DMA_W-1:0]  dreg [DMA_N];

  wire [IDX_W-1:0]  idx    = reg_addr[ADDR_W-1:2];
  wire [DSEL_W-1:0] dsel   = dma_addr[DSEL_W+1:2];
  wire              cmd_wr = reg_wr_en && (idx == IDX_W'(CMD_IDX));
  wire [6:0]        op     = reg_wdata[6:0];
  wire              do_rst = cmd_wr && (op == 7'h02);
  wire              do_sel = cmd_wr && (op == 7'h42);
  wire              store  = reg_wr_en && ((idx < IDX_W'(3)) || (idx == IDX_W'(8)));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RV = (i == ID_IDX) ? ID_VAL : '0;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q <= RV;
      else if (do_rst)                  q <= RV;
      else if (do_sel && i == STAT_IDX) q <= STAT_VAL;
      else if (do_sel && i == INTR_IDX) q <= INTR_VAL;
      else if (do_sel && i == SEQ_IDX)  q <= SEQ_VAL;
      else if (store && idx == IDX_W'(i)) q <= reg_wdata;
    end
    assign bank[i] = q;
  end

  for (genvar j = 0; j < DMA_N; j++) begin : g_dma
    logic [DMA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (do_rst)                        q <= '0;
      else if (dma_wr_en && dsel == DSEL_W'(j)) q <= dma_wdata;
    end
    assign dreg[j] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (do_rst)  irq <= 1'b0;
    else if (do_sel)  irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  assign reg_rdata = bank[idx];
  assign dma_rdata = dreg[dsel];
endmodule

// File: rtl/scsi_regfront_chk.sv
module scsi_regfront_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic [5:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq_clr,
  input logic       irq
);
  wire cmd = reg_wr_en && reg_addr[5:2] == 4'd3;

  // R6
  sel_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && reg_wdata[6:0] == 7'h42 |=> irq);

  // R7
  chip_reset_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && reg_wdata[6:0] == 7'h02 |=> !irq);

  // R9
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr && !(cmd && reg_wdata[6:0] == 7'h02) |=> irq);

  // R9
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cmd && reg_wdata[6:0] == 7'h42));

  // R5
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[5:2] == 4'd3 |-> reg_rdata == 8'h00);
endmodule

bind scsi_regfront scsi_regfront_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_clr(irq_clr), .irq(irq)
);

// File: tb/scsi_regfront_tb.sv
`timescale 1ns/1ps
module scsi_regfront_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0, dma_wr_en = 1'b0, irq_clr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [3:0] dma_addr = '0;
  logic [31:0] dma_wdata = '0, dma_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scsi_regfront dut_i (.clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_wr_en(dma_wr_en), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .irq_clr(irq_clr), .irq(irq));

  // {req, wr addr, wr data, rd addr, expected}
  localparam int NV = 13;
  localparam logic [35:0] VEC [NV] = '{
    {8'd3,  6'h00, 8'h11, 6'h00, 8'h11},  // R3
    {8'd2,  6'h05, 8'h22, 6'h04, 8'h22},  // R2
    {8'd2,  6'h08, 8'h33, 6'h0B, 8'h33},  // R2
    {8'd3,  6'h20, 8'h44, 6'h20, 8'h44},  // R3
    {8'd4,  6'h10, 8'h99, 6'h10, 8'h00},  // R4
    {8'd4,  6'h1C, 8'h99, 6'h1C, 8'h00},  // R4
    {8'd4,  6'h24, 8'h77, 6'h24, 8'h00},  // R4
    {8'd4,  6'h38, 8'h55, 6'h38, 8'h04},  // R4
    {8'd4,  6'h3C, 8'hAA, 6'h3C, 8'h00},  // R4
    {8'd5,  6'h0C, 8'h00, 6'h0C, 8'h00},  // R5
    {8'd8,  6'h0C, 8'h1A, 6'h00, 8'h11},  // R8
    {8'd8,  6'h0C, 8'h03, 6'h20, 8'h44},  // R8
    {8'd8,  6'h0C, 8'h55, 6'h10, 8'h00}   // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input string req, input logic [5:0] a, input logic [7:0] exp);
    reg_addr = a; #1; chk(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic wr_dma(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); dma_wr_en = 1'b1; dma_addr = a; dma_wdata = d;
    @(negedge clk); dma_wr_en = 1'b0;
  endtask

  task automatic rd_dma(input string req, input logic [3:0] a, input logic [31:0] exp);
    dma_addr = a; #1; chk(req, dma_rdata, exp);
  endtask

  task automatic reset_state(input string req);
    for (int i = 0; i < 16; i++) rd_reg(req, 6'(i * 4), (i == 14) ? 8'h04 : 8'h00);
    for (int j = 0; j < 4; j++) rd_dma(req, 4'(j * 4), 32'h0);
    chk(req, {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_state("R1");

    for (int k = 0; k < NV; k++) begin
      wr_reg(VEC[k][27:22], VEC[k][21:14]);
      rd_reg($sformatf("R%0d row %0d", VEC[k][35:28], k), VEC[k][13:8], VEC[k][7:0]);
    end
    chk("R8", {31'd0, irq}, 32'd0);

    // R6: select with bit 7 set
    wr_reg(6'h0C, 8'hC2);
    rd_reg("R6", 6'h10, 8'h1A);
    rd_reg("R6", 6'h14, 8'h20);
    rd_reg("R6", 6'h18, 8'h04);
    rd_reg("R5", 6'h0C, 8'h00);
    chk("R6", {31'd0, irq}, 32'd1);

    // R9: hold, then clear
    wr_reg(6'h0C, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9", {31'd0, irq}, 32'd1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R9", {31'd0, irq}, 32'd0);

    // R9: select and clear same cycle
    @(negedge clk); irq_clr = 1'b1; reg_wr_en = 1'b1; reg_addr = 6'h0C; reg_wdata = 8'h42;
    @(negedge clk); irq_clr = 1'b0; reg_wr_en = 1'b0;
    chk("R9", {31'd0, irq}, 32'd1);

    // R10 and R2 on DMA window
    wr_dma(4'h0, 32'hDEAD_0001);
    wr_dma(4'h5, 32'hCAFE_0002);
    wr_dma(4'hA, 32'h1234_5678);
    wr_dma(4'hF, 32'hFFFF_0004);
    rd_dma("R10", 4'h0, 32'hDEAD_0001);
    rd_dma("R2",  4'h4, 32'hCAFE_0002);
    rd_dma("R10", 4'h8, 32'h1234_5678);
    rd_dma("R10", 4'hC, 32'hFFFF_0004);
    wr_dma(4'h4, 32'h0BAD_F00D);
    rd_dma("R10", 4'h0, 32'hDEAD_0001);
    rd_dma("R10", 4'h7, 32'h0BAD_F00D);

    // R7: chip reset wins over a DMA write in the same cycle
    @(negedge clk); dma_wr_en = 1'b1; dma_addr = 4'h8; dma_wdata = 32'h5555_5555;
    reg_wr_en = 1'b1; reg_addr = 6'h0C; reg_wdata = 8'h02;
    @(negedge clk); dma_wr_en = 1'b0; reg_wr_en = 1'b0;
    reset_state("R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule